// File: doc/BRIEF.md
# Serial Link Data-Valid Monitor

This block sits behind a clock-recovery stage and watches the recovered serial stream, one bit per clock cycle whenever a bit strobe is asserted. It produces a single flag that tells downstream logic whether the link is carrying well-formed 8B/10B traffic. Two conditions are checked. First, the stream must never hold more than five identical bits in a row. Second, the seven-bit positive-disparity comma pattern must keep arriving.

Errors are gathered over windows of a fixed number of received bits, 2^15 by default. At the end of each window the block issues a verdict. It also emits one-cycle debug pulses that name the kinds of error the window held. A mode input selects how the verdict reaches the flag. In one setting the flag follows each window directly. In the other, the flag changes only after a run of four windows that all disagree with its current state.

Top module: `link_valid_monitor`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `dv_o`, `run_err_o` and `nocomma_err_o` are all 0.
- R2: A run-length violation is recorded on the sixth consecutive identical valid bit, for both ones and zeros. A run of exactly five identical bits is not a violation.
- R3: A comma is recorded when the seven most recent valid bits, oldest first, are 0011111.
- R4: A window is exactly 2^INTERVAL_LOG2 valid bits. In the cycle after the last bit of a window, `run_err_o` pulses for one cycle if the window held a violation, and `nocomma_err_o` pulses for one cycle if it held no comma. Both outputs are 0 in every other cycle.
- R5: With `mode_i` = 0 (single), `dv_o` is set to 1 if the window just ended was good and to 0 if it was bad. The update happens one cycle after the debug pulses. A window is bad if it held a violation or held no comma.
- R6: With `mode_i` = 1 (filtered) and `dv_o` high, `dv_o` falls only at the end of the fourth consecutive bad window.
- R7: With `mode_i` = 1 and `dv_o` low, `dv_o` rises only at the end of the fourth consecutive good window.
- R8: Any change of `mode_i` clears the count of consecutive disagreeing windows.
- R9: Cycles with `bit_valid_i` = 0 advance neither the window position nor the run or comma checkers, whatever `bit_i` holds.
- R10: The run counter and the comma history carry across window boundaries. A pattern that straddles a boundary counts in the window where its last bit arrives.
- R11: `dv_o` changes only in the cycle that follows a window verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bit_i | input | 1 | Recovered serial bit |
| bit_valid_i | input | 1 | High when `bit_i` carries a new bit |
| mode_i | input | 1 | 0 = single-window, 1 = four-window filter |
| dv_o | output | 1 | Data-valid flag |
| run_err_o | output | 1 | One-cycle pulse: the ended window held a run-length violation |
| nocomma_err_o | output | 1 | One-cycle pulse: the ended window held no comma |

## Verification
A wrong bit-position count moves every debug pulse away from the cycle after the window's last bit. This is visible within one window. A fault in the run or comma tracking gives a wrong pulse pattern at the end of the affected window. When the fault lies in the state carried across a boundary, the wrong pulse appears at the end of the next window instead. A broken consecutive-window counter shows only at the flag: the flag moves at the second, third or fifth disagreeing window instead of the fourth. This can take up to five windows to show. A counter that ignores mode changes shows at the first window after a mode toggle.

// File: rtl/lvm_pkg.sv
package lvm_pkg;

   typedef enum logic {
      MODE_SINGLE = 1'b0,
      MODE_MULTI  = 1'b1
   } lvm_mode_e;

   typedef struct packed {
      logic run_err;
      logic no_comma;
   } lvm_verdict_t;

endpackage

// File: rtl/lvm_run_check.sv
module lvm_run_check #(
   parameter int RUN_LIMIT = 5
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic bit_i,
   input  logic valid_i,
   output logic viol_o
);
   localparam int RW = $clog2(RUN_LIMIT + 2);
   localparam logic [RW-1:0] SAT_V = RW'(RUN_LIMIT + 1);

   logic [RW-1:0] run_q, run_nx;
   logic          last_q;

   always_comb begin
      run_nx = run_q;
      if (valid_i) begin
         if (run_q == '0 || bit_i != last_q) run_nx = RW'(1);
         else if (run_q != SAT_V)            run_nx = run_q + 1'b1;
      end
   end

   assign viol_o = valid_i && (run_nx == SAT_V);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         run_q  <= '0;
         last_q <= 1'b0;
      end else if (valid_i) begin
         run_q  <= run_nx;
         last_q <= bit_i;
      end
   end
endmodule

// File: rtl/lvm_comma_check.sv
module lvm_comma_check #(
   parameter int                PAT_LEN = 7,
   parameter logic [PAT_LEN-1:0] PATTERN = 7'b0011111
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic bit_i,
   input  logic valid_i,
   output logic hit_o
);
   localparam int FW = (PAT_LEN > 2) ? $clog2(PAT_LEN) : 1;
   localparam logic [FW-1:0] FULL_V = FW'(PAT_LEN - 1);

   logic [PAT_LEN-1:0] hist_q, hist_nx;
   logic [FW-1:0]      fill_q;

   generate
      if (PAT_LEN < 2) begin : g_bad_len
         $error("lvm_comma_check: PAT_LEN must be at least 2");
      end
   endgenerate

   assign hist_nx = {hist_q[PAT_LEN-2:0], bit_i};
   assign hit_o   = valid_i && (fill_q == FULL_V) && (hist_nx == PATTERN);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         hist_q <= '0;
         fill_q <= '0;
      end else if (valid_i) begin
         hist_q <= hist_nx;
         if (fill_q != FULL_V) fill_q <= fill_q + 1'b1;
      end
   end
endmodule

// File: rtl/lvm_interval.sv
module lvm_interval
   import lvm_pkg::*;
#(
   parameter int INTERVAL_LOG2 = 15
) (
   input  logic                     clk_i,
   input  logic                     rst_i,
   input  logic                     valid_i,
   input  logic                     viol_i,
   input  logic                     comma_i,
   output logic                     end_o,
   output lvm_verdict_t             verdict_o,
   output logic [INTERVAL_LOG2-1:0] pos_o
);
   logic [INTERVAL_LOG2-1:0] pos_q;
   logic                     viol_seen_q, comma_seen_q;
   logic                     last_bit;

   assign last_bit = valid_i && (&pos_q);
   assign pos_o    = pos_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pos_q        <= '0;
         viol_seen_q  <= 1'b0;
         comma_seen_q <= 1'b0;
         end_o        <= 1'b0;
         verdict_o    <= '0;
      end else begin
         end_o <= last_bit;
         if (valid_i) begin
            pos_q <= pos_q + 1'b1;
            if (last_bit) begin
               verdict_o.run_err  <= viol_seen_q | viol_i;
               verdict_o.no_comma <= ~(comma_seen_q | comma_i);
               viol_seen_q        <= 1'b0;
               comma_seen_q       <= 1'b0;
            end else begin
               viol_seen_q  <= viol_seen_q | viol_i;
               comma_seen_q <= comma_seen_q | comma_i;
            end
         end
      end
   end
endmodule

// File: rtl/lvm_flag_filter.sv
module lvm_flag_filter
   import lvm_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic      clk_i,
   input  logic      rst_i,
   input  logic      end_i,
   input  logic      bad_i,
   input  lvm_mode_e mode_i,
   output logic      flag_o
);
   logic      flag_q, flag_nx;
   lvm_mode_e mode_q;
   logic      mode_chg;

   assign mode_chg = (mode_i != mode_q);
   assign flag_o   = flag_q;

   generate
      if (DEPTH < 2) begin : g_plain
         always_comb begin
            flag_nx = flag_q;
            if (end_i) flag_nx = ~bad_i;
         end
      end else begin : g_filt
         localparam int CW = $clog2(DEPTH);
         localparam logic [CW-1:0] LAST_V = CW'(DEPTH - 1);
         logic [CW-1:0] cnt_q, cnt_nx;

         always_comb begin
            flag_nx = flag_q;
            cnt_nx  = mode_chg ? '0 : cnt_q;
            if (end_i) begin
               if (mode_i == MODE_SINGLE) begin
                  flag_nx = ~bad_i;
                  cnt_nx  = '0;
               end else if (bad_i == flag_q) begin
                  if (cnt_nx == LAST_V) begin
                     flag_nx = ~flag_q;
                     cnt_nx  = '0;
                  end else begin
                     cnt_nx = cnt_nx + 1'b1;
                  end
               end else begin
                  cnt_nx = '0;
               end
            end
         end

         always_ff @(posedge clk_i) begin
            if (rst_i) cnt_q <= '0;
            else       cnt_q <= cnt_nx;
         end
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         flag_q <= 1'b0;
         mode_q <= MODE_SINGLE;
      end else begin
         flag_q <= flag_nx;
         mode_q <= mode_i;
      end
   end
endmodule

// File: rtl/link_valid_monitor.sv
module link_valid_monitor
   import lvm_pkg::*;
#(
   parameter int INTERVAL_LOG2 = 15,
   parameter int RUN_LIMIT     = 5,
   parameter int FILTER_DEPTH  = 4,
   parameter int COMMA_LEN     = 7,
   parameter logic [COMMA_LEN-1:0] COMMA_PAT = 7'b0011111
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic bit_i,
   input  logic bit_valid_i,
   input  logic mode_i,
   output logic dv_o,
   output logic run_err_o,
   output logic nocomma_err_o
);
   generate
      if (INTERVAL_LOG2 < 4 || INTERVAL_LOG2 > 31) begin : g_bad_ilog
         $error("link_valid_monitor: INTERVAL_LOG2 out of range");
      end
      if (RUN_LIMIT < 1) begin : g_bad_run
         $error("link_valid_monitor: RUN_LIMIT must be positive");
      end
      if (FILTER_DEPTH < 1) begin : g_bad_depth
         $error("link_valid_monitor: FILTER_DEPTH must be positive");
      end
   endgenerate

   logic                     viol_w, comma_w, end_w, bad_w;
   lvm_verdict_t             verdict_w;
   logic [INTERVAL_LOG2-1:0] bit_cnt_w;

   lvm_run_check #(.RUN_LIMIT(RUN_LIMIT)) u_run (
      .clk_i(clk_i), .rst_i(rst_i), .bit_i(bit_i),
      .valid_i(bit_valid_i), .viol_o(viol_w)
   );

   lvm_comma_check #(.PAT_LEN(COMMA_LEN), .PATTERN(COMMA_PAT)) u_comma (
      .clk_i(clk_i), .rst_i(rst_i), .bit_i(bit_i),
      .valid_i(bit_valid_i), .hit_o(comma_w)
   );

   lvm_interval #(.INTERVAL_LOG2(INTERVAL_LOG2)) u_win (
      .clk_i(clk_i), .rst_i(rst_i), .valid_i(bit_valid_i),
      .viol_i(viol_w), .comma_i(comma_w), .end_o(end_w),
      .verdict_o(verdict_w), .pos_o(bit_cnt_w)
   );

   assign bad_w = verdict_w.run_err | verdict_w.no_comma;

   lvm_flag_filter #(.DEPTH(FILTER_DEPTH)) u_flag (
      .clk_i(clk_i), .rst_i(rst_i), .end_i(end_w), .bad_i(bad_w),
      .mode_i(lvm_mode_e'(mode_i)), .flag_o(dv_o)
   );

   assign run_err_o     = end_w & verdict_w.run_err;
   assign nocomma_err_o = end_w & verdict_w.no_comma;
endmodule

// File: rtl/lvm_checker.sv
module lvm_checker #(
   parameter int INTERVAL_LOG2 = 15
) (
   input logic                     clk_i,
   input logic                     rst_i,
   input logic                     bit_valid_i,
   input logic                     mode_i,
   input logic                     dv_o,
   input logic                     run_err_o,
   input logic                     nocomma_err_o,
   input logic                     end_w,
   input logic                     bad_w,
   input logic [INTERVAL_LOG2-1:0] bit_cnt_w
);
   p_reset_clear_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(rst_i) |-> (!dv_o && !run_err_o && !nocomma_err_o));

   p_pulse_at_end_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      (run_err_o || nocomma_err_o) |-> end_w);

   p_single_follow_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (end_w && !mode_i) |=> (dv_o == !$past(bad_w)));

   p_gate_idle_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      !bit_valid_i |=> $stable(bit_cnt_w));

   p_flag_boundary_r11: assert property (@(posedge clk_i) disable iff (rst_i)
      !$stable(dv_o) |-> $past(end_w));
endmodule

bind link_valid_monitor lvm_checker #(.INTERVAL_LOG2(INTERVAL_LOG2)) u_chk (
   .clk_i(clk_i), .rst_i(rst_i), .bit_valid_i(bit_valid_i), .mode_i(mode_i),
   .dv_o(dv_o), .run_err_o(run_err_o), .nocomma_err_o(nocomma_err_o),
   .end_w(end_w), .bad_w(bad_w), .bit_cnt_w(bit_cnt_w)
);

// File: tb/tb_link_valid_monitor.sv
module tb_link_valid_monitor;
   localparam int CLK_PERIOD = 10;
   localparam int ILOG = 6;
   localparam int IBITS = 1 << ILOG;
   localparam logic [9:0] KWORD = 10'b0011111010;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_r = 1'b0;
   logic valid_r = 1'b0;
   logic mode_r = 1'b0;
   logic dv_o, run_err_o, nocomma_err_o;

   int checks = 0;
   int errors = 0;
   logic flag_exp = 1'b0;
   int   cnt_exp = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   link_valid_monitor #(.INTERVAL_LOG2(ILOG)) dut (
      .clk_i(clk), .rst_i(rst), .bit_i(bit_r), .bit_valid_i(valid_r),
      .mode_i(mode_r), .dv_o(dv_o), .run_err_o(run_err_o),
      .nocomma_err_o(nocomma_err_o)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   // kinds: 0 good, 1 no comma, 2 run violation, 3 both, 4 comma only across the start boundary
   function automatic logic gen(input int kind, input int i);
      case (kind)
         0: return KWORD[9 - (i % 10)];
         1: return (i % 2 == 0);
         2: return (i < 6) ? 1'b0 : (i < 10) ? 1'b1 : KWORD[9 - (i % 10)];
         3: return (i < 6) ? 1'b0 : (i % 2 == 0);
         default: return (i < 3) ? 1'b1 : (i % 2 == 0);
      endcase
   endfunction

   task automatic send_interval(input int kind, input bit gaps);
      logic exp_run, exp_nc, bad;
      for (int i = 0; i < IBITS; i++) begin
         if (gaps && (i % 10 == 5)) begin
            for (int g = 0; g < 3; g++) begin
               @(negedge clk);
               valid_r = 1'b0;
               bit_r   = gen(kind, i - 1); // R9: idle bits that would lengthen a run
            end
         end
         @(negedge clk);
         if (i == IBITS / 2) check("R11 flag steady inside window", dv_o, flag_exp);
         if (i > 0) begin
            check("R4 no pulse inside window", run_err_o | nocomma_err_o, 1'b0);
         end
         bit_r   = gen(kind, i);
         valid_r = 1'b1;
      end
      exp_run = (kind == 2 || kind == 3);
      exp_nc  = (kind == 1 || kind == 3);
      bad     = exp_run | exp_nc;
      @(negedge clk);
      valid_r = 1'b0;
      check("R2/R4 run_err pulse", run_err_o, exp_run);
      check("R3/R10 nocomma pulse", nocomma_err_o, exp_nc);
      if (!mode_r) begin
         flag_exp = ~bad;
         cnt_exp  = 0;
      end else if (bad == flag_exp) begin
         if (cnt_exp == 3) begin
            flag_exp = ~flag_exp;
            cnt_exp  = 0;
         end else cnt_exp++;
      end else cnt_exp = 0;
      @(negedge clk);
      check(mode_r ? "R6/R7 filtered flag" : "R5 single flag", dv_o, flag_exp);
      check("R4 pulse lasts one cycle", run_err_o | nocomma_err_o, 1'b0);
   endtask

   task automatic set_mode(input logic m);
      @(negedge clk);
      mode_r  = m;
      cnt_exp = 0; // R8
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 flag low in reset", dv_o, 1'b0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 flag low after reset", dv_o, 1'b0);
      check("R1 pulses low after reset", run_err_o | nocomma_err_o, 1'b0);

      // single-window mode
      send_interval(0, 1'b0);  // R5 rise, R2 run of five ok
      send_interval(1, 1'b0);  // R3 no comma
      send_interval(0, 1'b1);  // R9 idle cycles ignored
      send_interval(2, 1'b0);  // R2 six zeros
      send_interval(0, 1'b0);
      send_interval(4, 1'b0);  // R10 straddling comma counts here
      send_interval(3, 1'b0);
      send_interval(0, 1'b1);

      // filtered mode
      set_mode(1'b1);
      send_interval(1, 1'b0);
      send_interval(2, 1'b0);
      send_interval(3, 1'b0);
      send_interval(0, 1'b0);  // R6 breaks the bad run
      send_interval(1, 1'b0);
      send_interval(1, 1'b0);
      send_interval(1, 1'b0);
      send_interval(1, 1'b0);  // R6 falls on fourth
      send_interval(0, 1'b0);
      send_interval(0, 1'b1);
      send_interval(0, 1'b0);
      send_interval(1, 1'b0);  // R7 breaks the good run
      send_interval(0, 1'b0);
      send_interval(0, 1'b0);
      send_interval(0, 1'b0);
      send_interval(4, 1'b0);  // R7 rises on fourth
      // R8: two bad, toggle mode, then need four more
      send_interval(1, 1'b0);
      send_interval(2, 1'b0);
      set_mode(1'b0);
      set_mode(1'b1);
      send_interval(1, 1'b0);
      send_interval(1, 1'b0);
      send_interval(1, 1'b0);
      check("R8 count cleared by mode change", dv_o, 1'b1);
      send_interval(1, 1'b0);
      check("R8 falls after four fresh bad windows", dv_o, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule